// File: doc/BRIEF.md
# I/O-Mapped Watchdog Timer

The block is a watchdog supervised by host read cycles on a small I/O bus. One port address arms the watchdog when it is idle and reloads its full timeout when it is already counting; a second port address disarms it. Reads at any other address are ignored. Software keeps the system alive by reading the arm/reload port before the selected period runs out.

The timeout is picked by a 3-bit board strap from six uneven steps (1, 2, 10, 20, 110 and 220 seconds). A prescaler derives a one-second tick from the system clock, and the tick counter runs down the remaining seconds. A 2-bit action strap decides what happens when the count runs out: a one-clock NMI pulse, a multi-clock system reset pulse, or no output at all. After any expiry the watchdog returns to the disarmed state. A status output and a remaining-seconds output make the state visible.

Top module: `io_watchdog`

## Requirements
- R1: After synchronous reset `wdt_enabled` is 0, `wdt_secs_left` is 0, and `wdt_nmi` and `wdt_reset` are 0; the disarmed watchdog does not count.
- R2: A read strobe with `rd_addr` = 0x0443 while disarmed arms the watchdog: on the next clock `wdt_enabled` is 1 and `wdt_secs_left` holds the selected period in seconds.
- R3: `period_strap` code selects the period: 3'b111 = 1 s, 3'b110 = 2 s, 3'b101 = 10 s, 3'b100 = 20 s, 3'b011 = 110 s, 3'b010 = 220 s; the unused codes 3'b001 and 3'b000 give 1 s.
- R4: A read of 0x0443 while armed reloads the full period from the strap value present at that read and restarts the one-second prescaler; a strap change takes effect only at such a read.
- R5: A read strobe with `rd_addr` = 0x0045 disarms the watchdog on the next clock (`wdt_enabled` 0, `wdt_secs_left` 0) and no expiry action follows.
- R6: With no further arm/reload read, expiry takes effect on the clock edge exactly P x CLK_HZ clocks after the edge that captured the last arm/reload read (P = period in seconds); at that edge the watchdog becomes disarmed.
- R7: With `action_strap` = 2'b01 (NMI), expiry drives `wdt_nmi` high for exactly one clock, and `wdt_reset` stays low.
- R8: With `action_strap` = 2'b10 or 2'b11 (system reset), expiry drives `wdt_reset` high for exactly RST_PULSE_CLKS clocks (default 16), and `wdt_nmi` stays low.
- R9: With `action_strap` = 2'b00 (off), expiry drives neither output, but the watchdog still becomes disarmed.
- R10: A strobe at any other address, or either port address with `rd_strobe` low, changes nothing.
- R11: While armed, `wdt_secs_left` drops by one every CLK_HZ clocks counted from the last arm/reload edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_strobe | input | 1 | One-cycle I/O read strobe |
| rd_addr | input | ADDR_W | I/O address qualified by `rd_strobe` |
| period_strap | input | 3 | Timeout period select code |
| action_strap | input | 2 | Expiry action: 01 NMI, 10/11 reset, 00 off |
| wdt_nmi | output | 1 | One-clock NMI pulse on expiry |
| wdt_reset | output | 1 | System reset pulse on expiry |
| wdt_enabled | output | 1 | Watchdog armed |
| wdt_secs_left | output | 8 | Whole seconds remaining in the current period |

## Verification
On every cycle the assertions check that the two port decodes never fire together, that a disarm read always leaves the block idle, that an armed count is never zero and falls by exactly one on a tick, that the NMI pulse is a single clock, that the two outputs never overlap, and that each reset pulse has the configured length. The bench alone can show the absolute expiry timing measured from the last reload, the full period table including the fallback codes, that a strap change waits for the next reload, and that a disarm or an off action produces no output at all. Its scoreboard holds each expected expiry with its cycle and kind, and flags any pulse that was not expected.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int SECS_W = 8;

  typedef enum logic [1:0] {
    ACT_OFF  = 2'b00,
    ACT_NMI  = 2'b01,
    ACT_RST  = 2'b10,
    ACT_RST2 = 2'b11
  } wdt_action_e;

  // Period strap code to whole seconds; unused codes fall back to 1 s.
  function automatic logic [SECS_W-1:0] period_secs(input logic [2:0] code);
    logic [SECS_W-1:0] s;
    case (code)
      3'b111:  s = SECS_W'(1);
      3'b110:  s = SECS_W'(2);
      3'b101:  s = SECS_W'(10);
      3'b100:  s = SECS_W'(20);
      3'b011:  s = SECS_W'(110);
      3'b010:  s = SECS_W'(220);
      default: s = SECS_W'(1);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/wdt_decode.sv
module wdt_decode #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] ARM_ADDR = 16'h0443,
  parameter logic [15:0] OFF_ADDR = 16'h0045
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              arm_hit,
  output logic              off_hit
);

  localparam logic [ADDR_W-1:0] ARM_A = ADDR_W'(ARM_ADDR);
  localparam logic [ADDR_W-1:0] OFF_A = ADDR_W'(OFF_ADDR);

  always_comb begin
    arm_hit = rd_strobe && (rd_addr == ARM_A);
    off_hit = rd_strobe && (rd_addr == OFF_A);
  end

  // R10: a single strobe decodes to at most one port
  assert_one_port_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arm_hit, off_hit}));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);

  localparam int PRE_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CLK_HZ - 1);

  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt <= '0;
    else if (cnt == LAST)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  always_comb tick = run && (cnt == LAST);

  // R11: after a tick the prescaler always restarts from zero
  assert_restart_after_tick_R11: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_hit,
  input  logic              off_hit,
  input  logic              tick,
  input  logic [2:0]        period_strap,
  output logic              enabled,
  output logic [SECS_W-1:0] secs_left,
  output logic              expire
);

  logic last_sec;

  always_comb begin
    last_sec = (secs_left == SECS_W'(1));
    expire   = enabled && tick && last_sec && !arm_hit && !off_hit;
  end

  always_ff @(posedge clk) begin
    if (rst || off_hit) begin
      enabled   <= 1'b0;
      secs_left <= '0;
    end else if (arm_hit) begin
      enabled   <= 1'b1;
      secs_left <= period_secs(period_strap);
    end else if (enabled && tick) begin
      if (last_sec) begin
        enabled   <= 1'b0;
        secs_left <= '0;
      end else begin
        secs_left <= secs_left - 1'b1;
      end
    end
  end

  // R5: a disarm read always leaves the block idle
  assert_off_idles_R5: assert property (@(posedge clk) disable iff (rst)
    off_hit |=> (!enabled && secs_left == '0));

  // R4: an arm/reload read always leaves the block armed with a nonzero count
  assert_reload_arms_R4: assert property (@(posedge clk) disable iff (rst)
    arm_hit |=> (enabled && secs_left != '0));

  // R11: an armed count is never zero
  assert_armed_nonzero_R11: assert property (@(posedge clk) disable iff (rst)
    enabled |-> (secs_left != '0));

  // R11: a tick with no read lowers the count by one
  assert_tick_decrements_R11: assert property (@(posedge clk) disable iff (rst)
    (enabled && tick && !arm_hit && !off_hit && secs_left > SECS_W'(1))
      |=> (secs_left == $past(secs_left) - 1'b1));

  // R6: expiry disarms the watchdog
  assert_expire_disarms_R6: assert property (@(posedge clk) disable iff (rst)
    expire |=> !enabled);

endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
#(
  parameter int RST_PULSE_CLKS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       expire,
  input  logic [1:0] action_strap,
  output logic       nmi_o,
  output logic       reset_o
);

  localparam int RST_W = $clog2(RST_PULSE_CLKS + 1);
  localparam logic [RST_W-1:0] RST_LOAD = RST_W'(RST_PULSE_CLKS - 1);

  wdt_action_e act;
  logic        want_nmi, want_rst;
  logic [RST_W-1:0] rst_cnt;

  always_comb begin
    act      = wdt_action_e'(action_strap);
    want_nmi = expire && (act == ACT_NMI);
    want_rst = expire && (act == ACT_RST || act == ACT_RST2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_o   <= 1'b0;
      reset_o <= 1'b0;
      rst_cnt <= '0;
    end else begin
      nmi_o <= want_nmi;
      if (want_rst) begin
        reset_o <= 1'b1;
        rst_cnt <= RST_LOAD;
      end else if (rst_cnt != '0) begin
        rst_cnt <= rst_cnt - 1'b1;
      end else begin
        reset_o <= 1'b0;
      end
    end
  end

  // R7: NMI is a single-clock pulse
  assert_nmi_single_R7: assert property (@(posedge clk) disable iff (rst)
    nmi_o |=> !nmi_o);

  // R9: the two expiry outputs never overlap
  assert_outputs_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(nmi_o && reset_o));

  // R9: an expiry with the action off drives nothing new
  assert_off_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (expire && act == ACT_OFF) |=> (!nmi_o && !$rose(reset_o)));

  // R8: reset pulse length measured by a checker counter
  logic [RST_W:0] hi_len;
  always_ff @(posedge clk) begin
    if (rst)          hi_len <= '0;
    else if (reset_o) hi_len <= hi_len + 1'b1;
    else              hi_len <= '0;
  end

  assert_rst_len_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_o) |-> (hi_len == (RST_W+1)'(RST_PULSE_CLKS)));

endmodule

// File: rtl/io_watchdog.sv
module io_watchdog
  import wdt_pkg::*;
#(
  parameter int          CLK_HZ         = 50_000_000,
  parameter int          RST_PULSE_CLKS = 16,
  parameter int          ADDR_W         = 16,
  parameter logic [15:0] ARM_ADDR       = 16'h0443,
  parameter logic [15:0] OFF_ADDR       = 16'h0045
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [2:0]        period_strap,
  input  logic [1:0]        action_strap,
  output logic              wdt_nmi,
  output logic              wdt_reset,
  output logic              wdt_enabled,
  output logic [7:0]        wdt_secs_left
);

  logic arm_hit, off_hit, tick, expire;
  logic [SECS_W-1:0] secs;

  wdt_decode #(
    .ADDR_W   (ADDR_W),
    .ARM_ADDR (ARM_ADDR),
    .OFF_ADDR (OFF_ADDR)
  ) u_decode (
    .clk       (clk),
    .rst       (rst),
    .rd_strobe (rd_strobe),
    .rd_addr   (rd_addr),
    .arm_hit   (arm_hit),
    .off_hit   (off_hit)
  );

  wdt_prescaler #(.CLK_HZ(CLK_HZ)) u_prescaler (
    .clk  (clk),
    .rst  (rst),
    .run  (wdt_enabled),
    .clr  (arm_hit),
    .tick (tick)
  );

  wdt_counter u_counter (
    .clk          (clk),
    .rst          (rst),
    .arm_hit      (arm_hit),
    .off_hit      (off_hit),
    .tick         (tick),
    .period_strap (period_strap),
    .enabled      (wdt_enabled),
    .secs_left    (secs),
    .expire       (expire)
  );

  wdt_action #(.RST_PULSE_CLKS(RST_PULSE_CLKS)) u_action (
    .clk          (clk),
    .rst          (rst),
    .expire       (expire),
    .action_strap (action_strap),
    .nmi_o        (wdt_nmi),
    .reset_o      (wdt_reset)
  );

  always_comb wdt_secs_left = 8'(secs);

endmodule

// File: tb/io_watchdog_bench.sv
module io_watchdog_bench;

  localparam int HZ = 20;
  localparam int RPULSE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_strobe = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [2:0] period_strap = 3'b111;
  logic [1:0] action_strap = 2'b00;
  logic wdt_nmi, wdt_reset, wdt_enabled;
  logic [7:0] wdt_secs_left;

  io_watchdog #(.CLK_HZ(HZ), .RST_PULSE_CLKS(RPULSE)) u_io_watchdog (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .period_strap(period_strap), .action_strap(action_strap),
    .wdt_nmi(wdt_nmi), .wdt_reset(wdt_reset),
    .wdt_enabled(wdt_enabled), .wdt_secs_left(wdt_secs_left)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct { int at; bit is_rst; } exp_t;
  exp_t expq[$];
  int events_seen = 0;

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic int exp_period(input logic [2:0] c);
    case (c)
      3'b010: return 220;
      3'b011: return 110;
      3'b100: return 20;
      3'b101: return 10;
      3'b110: return 2;
      default: return 1;
    endcase
  endfunction

  // One-cycle read strobe; returns the edge count that captured it.
  task automatic rd(input logic [15:0] a, output int edge_at);
    @(negedge clk);
    rd_strobe = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_strobe = 1'b0;
    rd_addr = '0;
    edge_at = cyc;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side of the scoreboard: arm and queue the expected expiry.
  task automatic arm_expect(input logic [2:0] code, input logic [1:0] act, input bit push);
    int e;
    exp_t x;
    period_strap = code;
    action_strap = act;
    rd(16'h0443, e);
    if (push) begin
      x.at = e + exp_period(code) * HZ;
      x.is_rst = act[1];
      expq.push_back(x);
    end
  endtask

  // Monitor side of the scoreboard.
  bit prev_nmi = 0, prev_rst = 0;
  int rst_len = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if ((wdt_nmi && !prev_nmi) || (wdt_reset && !prev_rst)) begin
        events_seen++;
        if (expq.size() == 0) begin
          check("R6 unexpected expiry pulse", cyc, -1);
        end else begin
          exp_t x;
          x = expq.pop_front();
          check("R6 expiry cycle", cyc, x.at);
          check("R7/R8 expiry kind (1=reset)", int'(wdt_reset), int'(x.is_rst));
        end
      end
      if (wdt_reset) rst_len++;
      if (!wdt_reset && prev_rst) begin
        check("R8 reset pulse length", rst_len, RPULSE);
        rst_len = 0;
      end
      if (wdt_nmi && prev_nmi) check("R7 NMI longer than one clock", 2, 1);
      prev_nmi = wdt_nmi;
      prev_rst = wdt_reset;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int e;
    int seen;
    wait_clks(3);
    rst = 1'b0;
    wait_clks(1);
    // R1 reset state
    check("R1 enabled after reset", wdt_enabled, 0);
    check("R1 secs after reset", wdt_secs_left, 0);
    check("R1 nmi after reset", wdt_nmi, 0);
    check("R1 reset out after reset", wdt_reset, 0);
    wait_clks(2 * HZ);
    check("R1 no counting while disarmed", wdt_secs_left, 0);

    // R10 ignored reads
    rd(16'h0444, e);
    check("R10 other address", wdt_enabled, 0);
    rd(16'h0043, e);
    check("R10 other address 2", wdt_enabled, 0);
    @(negedge clk); rd_addr = 16'h0443; @(negedge clk); rd_addr = '0;
    check("R10 address without strobe", wdt_enabled, 0);

    // R2/R3 period table, then R5 disarm
    for (int c = 0; c < 8; c++) begin
      arm_expect(3'(c), 2'b00, 0);
      check("R2 armed", wdt_enabled, 1);
      check($sformatf("R3 period code %0d", c), wdt_secs_left, exp_period(3'(c)));
      rd(16'h0045, e);
      check("R5 disarm enabled", wdt_enabled, 0);
      check("R5 disarm secs", wdt_secs_left, 0);
    end

    // R11 decrement timing, R10 ignored read while armed
    arm_expect(3'b101, 2'b00, 0);
    wait_clks(HZ - 1);
    check("R11 before first tick", wdt_secs_left, 10);
    wait_clks(1);
    check("R11 after one second", wdt_secs_left, 9);
    rd(16'h1443, e);
    wait_clks(HZ - 1);
    check("R10 read elsewhere kept count", wdt_secs_left, 8);
    rd(16'h0045, e);

    // R7 NMI expiry
    arm_expect(3'b111, 2'b01, 1);
    wait_clks(HZ + 5);
    check("R6 disarmed after NMI expiry", wdt_enabled, 0);

    // R8 reset expiry
    arm_expect(3'b110, 2'b10, 1);
    wait_clks(2 * HZ + RPULSE + 5);
    check("R6 disarmed after reset expiry", wdt_enabled, 0);

    // R8 code 11 also resets
    arm_expect(3'b111, 2'b11, 1);
    wait_clks(HZ + RPULSE + 5);

    // R4 refresh restarts and picks up new strap
    arm_expect(3'b111, 2'b10, 0);
    wait_clks(HZ - 5);
    arm_expect(3'b110, 2'b10, 1);
    check("R4 reload full new period", wdt_secs_left, 2);
    wait_clks(HZ + 3);
    check("R4 still armed after old deadline", wdt_enabled, 1);
    period_strap = 3'b101;
    wait_clks(HZ + RPULSE + 5);
    check("R4 strap change waits for reload", wdt_enabled, 0);

    // R9 off action
    seen = events_seen;
    arm_expect(3'b111, 2'b00, 0);
    wait_clks(HZ + 5);
    check("R9 disarmed after silent expiry", wdt_enabled, 0);
    check("R9 no output pulse", events_seen, seen);

    // R5 disarm before expiry
    arm_expect(3'b111, 2'b01, 0);
    wait_clks(HZ / 2);
    rd(16'h0045, e);
    wait_clks(2 * HZ);
    check("R5 no expiry after disarm", events_seen, seen);
    check("R5 stays disarmed", wdt_enabled, 0);

    check("R6 all expected expiries seen", expq.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule